// File: doc/BRIEF.md
# Auto-Increment Transfer Buffer Port

This block is the 512-byte staging store that sits between a host register port and a serial flash phase engine. Software uses three host-visible locations: a control word, a 32-bit data window and an engine start-pointer word. The control word selects the transfer direction, switches on automatic pointer stepping and holds the host word pointer. With direction set to transmit, each write to the data window stores one whole word. With direction set to receive, each read of the window returns one whole word. When stepping is on, the host word pointer then moves to the next word.

The serial engine works on single bytes. It starts at the byte address held in the engine start-pointer word, which software clears before each transfer. Each engine access moves that pointer on by one byte. Bytes are packed little-endian inside words. A transfer length that is not a multiple of four bytes therefore costs one extra full-word host access, and only the low-order bytes of that word carry payload.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset the host pointer, the direction bit, the stepping bit, the engine pointer, `hst_rdata` and `eng_rbyte` are all zero.
- R2: A host write with `hst_sel`=0 loads the direction from bit 31, stepping from bit 30 and the host word pointer from bits 6:0 (bit 7 of the 8-bit pointer field is not stored). A read with `hst_sel`=0 returns those fields in the same positions, with every other bit zero.
- R3: With direction 1 (host to buffer), a host write with `hst_sel`=1 stores all four bytes of `hst_wdata` in the word at the host pointer.
- R4: With direction 0 (buffer to host), a host read with `hst_sel`=1 returns the word at the host pointer on `hst_rdata` one cycle after the read strobe. That value is held until the next read.
- R5: An accepted window access advances the host pointer by one when stepping is set. With stepping clear the pointer holds, so repeated accesses reach the same word.
- R6: The host pointer wraps from word 127 to word 0.
- R7: A window access against the selected direction is ignored. With direction 0, a window write changes neither the buffer nor the pointer. With direction 1, a window read returns zero and leaves the pointer unchanged.
- R8: A host write with `hst_sel`=2 loads the 9-bit engine byte pointer from bits 8:0, and a read with `hst_sel`=2 returns it zero-extended. `hst_sel`=3 reads zero and ignores writes.
- R9: An engine access (`eng_req`) with `eng_we`=1 writes `eng_wbyte` at the engine pointer. With `eng_we`=0 it returns that byte on `eng_rbyte` one cycle later. Either way the pointer then advances by one byte and wraps from 511 to 0. A host load of the engine pointer in the same cycle takes precedence over the step.
- R10: Buffer byte 4n+k sits in bits 8k+7:8k of word n. A partial trailing word seen by the host carries the engine's bytes in its low-order lanes and leaves the upper lanes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 2 | Host location: 0 control, 1 data window, 2 engine pointer, 3 unused |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after the read strobe |
| eng_req | input | 1 | Engine byte access strobe |
| eng_we | input | 1 | Engine access is a write |
| eng_wbyte | input | 8 | Engine write byte |
| eng_rbyte | output | 8 | Engine read byte, valid the cycle after the access |

## Verification
Every host read result and every engine read byte is due exactly one clock edge after the edge that samples its strobe. Pointer and buffer updates take effect at that same edge, so the next access already sees them. The reference model advances at each rising edge on the inputs held stable since the previous falling edge. Both read outputs are compared with the model at every falling edge, which is where one-cycle latency puts the new values. Ignored accesses are followed by a control or window read, so any pointer or buffer change they caused shows up at the ports.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_EPTR = 2'd2,
    SEL_NONE = 2'd3
  } xbp_sel_e;

  localparam int CTRL_DIR_BIT  = 31;
  localparam int CTRL_AINC_BIT = 30;
  localparam int LANE_W        = 8;
endpackage

// File: rtl/xbp_lane_ram.sv
module xbp_lane_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  // engine port is written last: it wins a same-cell collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_re) a_q <= mem[a_addr];
      if (b_re) b_q <= mem[b_addr];
    end
  end
endmodule

// File: rtl/xbp_host_port.sv
module xbp_host_port
  import xbp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WPTR_W = 7,
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        hst_sel,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  input  logic [BPTR_W-1:0] eptr_val,
  input  logic [WORD_W-1:0] ram_q,
  output logic [WPTR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic              eptr_ld,
  output logic [BPTR_W-1:0] eptr_ld_val
);
  xbp_sel_e          sel;
  logic              dir_q, ainc_q, src_q;
  logic [WPTR_W-1:0] hptr_q;
  logic [WORD_W-1:0] reg_q, ctrl_view, rd_mux;
  logic              ctrl_wr, win_wr, win_rd, step;

  assign sel     = xbp_sel_e'(hst_sel);
  assign ctrl_wr = hst_wr && (sel == SEL_CTRL);
  assign win_wr  = hst_wr && (sel == SEL_WIN) && dir_q;
  assign win_rd  = hst_rd && (sel == SEL_WIN) && !dir_q;
  assign step    = (win_wr || win_rd) && ainc_q;

  assign ram_addr    = hptr_q;
  assign ram_we      = win_wr;
  assign ram_re      = win_rd;
  assign eptr_ld     = hst_wr && (sel == SEL_EPTR);
  assign eptr_ld_val = hst_wdata[BPTR_W-1:0];

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_DIR_BIT]  = dir_q;
    ctrl_view[CTRL_AINC_BIT] = ainc_q;
    ctrl_view[WPTR_W-1:0]    = hptr_q;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_view;
      SEL_EPTR: rd_mux = WORD_W'(eptr_val);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      ainc_q <= 1'b0;
      hptr_q <= '0;
      reg_q  <= '0;
      src_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        dir_q  <= hst_wdata[CTRL_DIR_BIT];
        ainc_q <= hst_wdata[CTRL_AINC_BIT];
        hptr_q <= hst_wdata[WPTR_W-1:0];
      end else if (step) begin
        hptr_q <= hptr_q + 1'b1;
      end
      if (hst_rd) begin
        src_q <= win_rd;
        reg_q <= rd_mux;
      end
    end
  end

  assign hst_rdata = src_q ? ram_q : reg_q;

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && (hptr_q == {WPTR_W{1'b1}})) |=> (hptr_q == '0));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((hst_wr || hst_rd) && (sel == SEL_WIN) && !ainc_q) |=> $stable(hptr_q));

  assert_wrong_dir_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && (sel == SEL_WIN) && !dir_q) |-> !ram_we);

  assert_wrong_dir_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && !hst_wr && (sel == SEL_WIN) && dir_q) |=> (hst_rdata == '0));
endmodule

// File: rtl/xbp_eng_port.sv
module xbp_eng_port
  import xbp_pkg::*;
#(
  parameter int BPTR_W = 9,
  parameter int LANES  = 4,
  localparam int LIDX_W = $clog2(LANES),
  localparam int WPTR_W = BPTR_W - LIDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    eng_req,
  input  logic                    eng_we,
  input  logic [LANE_W-1:0]       eng_wbyte,
  output logic [LANE_W-1:0]       eng_rbyte,
  input  logic                    eptr_ld,
  input  logic [BPTR_W-1:0]       eptr_ld_val,
  output logic [BPTR_W-1:0]       eptr_q,
  input  logic [LANES*LANE_W-1:0] lane_q,
  output logic [LANES-1:0]        lane_we,
  output logic                    word_re,
  output logic [WPTR_W-1:0]       word_addr,
  output logic [LANE_W-1:0]       wr_byte
);
  logic [LIDX_W-1:0] lsel_q;

  assign word_addr = eptr_q[BPTR_W-1:LIDX_W];
  assign word_re   = eng_req && !eng_we;
  assign wr_byte   = eng_wbyte;

  for (genvar k = 0; k < LANES; k++) begin : g_lane_we
    assign lane_we[k] = eng_req && eng_we && (eptr_q[LIDX_W-1:0] == LIDX_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eptr_q <= '0;
      lsel_q <= '0;
    end else begin
      if (eptr_ld)      eptr_q <= eptr_ld_val;
      else if (eng_req) eptr_q <= eptr_q + 1'b1;
      if (word_re)      lsel_q <= eptr_q[LIDX_W-1:0];
    end
  end

  assign eng_rbyte = lane_q[lsel_q*LANE_W +: LANE_W];

  assert_lane_we_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we));

  assert_eptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eptr_ld && (eptr_q == {BPTR_W{1'b1}})) |=> (eptr_q == '0));

  assert_eptr_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    eptr_ld |=> (eptr_q == $past(eptr_ld_val)));
endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port
  import xbp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        hst_sel,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [7:0]        eng_wbyte,
  output logic [7:0]        eng_rbyte
);
  localparam int LANES  = WORD_W / LANE_W;
  localparam int WORDS  = BUF_BYTES / LANES;
  localparam int WPTR_W = $clog2(WORDS);
  localparam int BPTR_W = $clog2(BUF_BYTES);

  logic [WORD_W-1:0]       ram_q;
  logic [WPTR_W-1:0]       h_addr, e_addr;
  logic                    h_we, h_re, e_re, eptr_ld;
  logic [BPTR_W-1:0]       eptr_ld_val, eptr;
  logic [LANES-1:0]        e_we;
  logic [LANES*LANE_W-1:0] e_q;
  logic [LANE_W-1:0]       e_wbyte;

  xbp_host_port #(.WORD_W(WORD_W), .WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_host (
    .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .eptr_val(eptr), .ram_q(ram_q),
    .ram_addr(h_addr), .ram_we(h_we), .ram_re(h_re),
    .eptr_ld(eptr_ld), .eptr_ld_val(eptr_ld_val)
  );

  xbp_eng_port #(.BPTR_W(BPTR_W), .LANES(LANES)) u_eng (
    .clk(clk), .rst(rst), .eng_req(eng_req), .eng_we(eng_we), .eng_wbyte(eng_wbyte),
    .eng_rbyte(eng_rbyte), .eptr_ld(eptr_ld), .eptr_ld_val(eptr_ld_val),
    .eptr_q(eptr), .lane_q(e_q), .lane_we(e_we), .word_re(e_re),
    .word_addr(e_addr), .wr_byte(e_wbyte)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    xbp_lane_ram #(.DEPTH(WORDS), .DW(LANE_W)) u_ram (
      .clk(clk), .rst(rst),
      .a_we(h_we), .a_re(h_re), .a_addr(h_addr),
      .a_wdata(hst_wdata[k*LANE_W +: LANE_W]), .a_q(ram_q[k*LANE_W +: LANE_W]),
      .b_we(e_we[k]), .b_re(e_re), .b_addr(e_addr),
      .b_wdata(e_wbyte), .b_q(e_q[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: tb/xfer_buf_port_bench.sv
module xfer_buf_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  hst_sel = 2'd0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        eng_req = 1'b0, eng_we = 1'b0;
  logic [7:0]  eng_wbyte = '0;
  logic [7:0]  eng_rbyte;

  always #2.5 clk = ~clk;

  xfer_buf_port u_xfer_buf_port (
    .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .eng_req(eng_req),
    .eng_we(eng_we), .eng_wbyte(eng_wbyte), .eng_rbyte(eng_rbyte)
  );

  // behavioural reference model
  logic [7:0]  mem [512];
  int          m_hptr = 0, m_eptr = 0;
  bit          m_dir = 0, m_ainc = 0;
  logic [31:0] exp_h = '0;
  logic [7:0]  exp_e = '0;
  int          o_h, o_e;
  bit          acc;
  string       phase = "R1";
  int          vectors = 0, misses = 0;
  bit          done = 0;

  function automatic logic [31:0] word_at(int p);
    return {mem[4*p+3], mem[4*p+2], mem[4*p+1], mem[4*p]};
  endfunction

  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      m_hptr = 0; m_eptr = 0; m_dir = 0; m_ainc = 0; exp_h = '0; exp_e = '0;
    end else begin
      o_h = m_hptr; o_e = m_eptr;
      acc = (hst_wr && hst_sel == 2'd1 && m_dir) || (hst_rd && hst_sel == 2'd1 && !m_dir);
      if (hst_rd) begin
        case (hst_sel)
          2'd0: exp_h = (32'(m_dir) << 31) | (32'(m_ainc) << 30) | 32'(o_h);
          2'd1: exp_h = m_dir ? 32'h0 : word_at(o_h);
          2'd2: exp_h = 32'(o_e);
          default: exp_h = 32'h0;
        endcase
      end
      if (eng_req && !eng_we) exp_e = mem[o_e];
      if (hst_wr && hst_sel == 2'd1 && m_dir)
        for (int k = 0; k < 4; k++) mem[4*o_h+k] = hst_wdata[8*k +: 8];
      if (eng_req && eng_we) mem[o_e] = eng_wbyte;
      if (acc && m_ainc) m_hptr = (o_h + 1) % 128;
      if (hst_wr && hst_sel == 2'd0) begin
        m_dir = hst_wdata[31]; m_ainc = hst_wdata[30]; m_hptr = int'(hst_wdata[6:0]);
      end
      if (hst_wr && hst_sel == 2'd2) m_eptr = int'(hst_wdata[8:0]);
      else if (eng_req) m_eptr = (o_e + 1) % 512;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (hst_rdata !== exp_h) begin
        misses++;
        $display("FAIL %s hst_rdata actual=%h expected=%h", phase, hst_rdata, exp_h);
      end
      vectors++;
      if (eng_rbyte !== exp_e) begin
        misses++;
        $display("FAIL %s eng_rbyte actual=%h expected=%h", phase, eng_rbyte, exp_e);
      end
    end
  end

  task automatic cyc(input logic [1:0] s, input logic w, input logic r, input logic [31:0] d,
                     input logic er, input logic ew, input logic [7:0] eb);
    hst_sel = s; hst_wr = w; hst_rd = r; hst_wdata = d;
    eng_req = er; eng_we = ew; eng_wbyte = eb;
    @(negedge clk);
  endtask

  task automatic hw(input logic [1:0] s, input logic [31:0] d);
    cyc(s, 1'b1, 1'b0, d, 1'b0, 1'b0, 8'h0);
  endtask

  task automatic hr(input logic [1:0] s);
    cyc(s, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h0);
  endtask

  task automatic ew(input logic [7:0] b);
    cyc(2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, b);
  endtask

  task automatic er();
    cyc(2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'h0);
  endtask

  task automatic idle();
    cyc(2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state through the readback paths
    phase = "R1";
    idle(); hr(2'd0); hr(2'd2); idle();
    // R2: control field layout, bit 7 of the pointer field not stored
    phase = "R2";
    hw(2'd0, 32'hC000_0085); hr(2'd0); hw(2'd3, 32'hFFFF_FFFF); hr(2'd3); hr(2'd0);
    // R3: fill every word from the host side
    phase = "R3";
    hw(2'd0, 32'hC000_0000);
    for (int i = 0; i < 128; i++) hw(2'd1, 32'(i) * 32'h9E37_79B1 + 32'h0102_0304);
    // R6: pointer wrapped back to zero after 128 writes
    phase = "R6";
    hr(2'd0);
    // R4 / R5: stepping reads
    phase = "R4";
    hw(2'd0, 32'h4000_0003); hr(2'd1); hr(2'd1); hr(2'd1); hr(2'd0);
    phase = "R5";
    hw(2'd0, 32'h0000_000A); hr(2'd1); idle(); hr(2'd1); hr(2'd0);
    phase = "R6";
    hw(2'd0, 32'h4000_007F); hr(2'd1); hr(2'd1); hr(2'd0);
    // R7: accesses against the selected direction
    phase = "R7";
    hw(2'd0, 32'h4000_0014); hw(2'd1, 32'hDEAD_BEEF); hr(2'd0); hr(2'd1);
    hw(2'd0, 32'hC000_0015); hr(2'd1); hr(2'd0);
    // R8: engine pointer register
    phase = "R8";
    hw(2'd2, 32'hFFFF_FFFD); hr(2'd2); hw(2'd2, 32'h0000_0000); hr(2'd2);
    // R9: engine writes across the wrap, load precedence, reads back
    phase = "R9";
    hw(2'd2, 32'h0000_01FE);
    ew(8'h11); ew(8'h22); ew(8'h33); ew(8'h44);
    hr(2'd2);
    cyc(2'd2, 1'b1, 1'b0, 32'h0000_0028, 1'b1, 1'b0, 8'h0);
    hr(2'd2);
    hw(2'd2, 32'h0000_01FE);
    er(); er(); er(); er(); idle(); hr(2'd2);
    // R10: partial trailing word seen by the host
    phase = "R10";
    hw(2'd2, 32'h0000_0040);
    for (int i = 1; i <= 6; i++) ew(8'(i));
    hw(2'd0, 32'h4000_0010); hr(2'd1); hr(2'd1);
    hw(2'd0, 32'h4000_0000); hr(2'd1); hr(2'd1);
    idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog phase %s actual=hung expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule